// File: doc/BRIEF.md
# Frozen-Snapshot Position Counter Byte Reader

This block keeps a 16-bit up/down position count and presents it to a host through an 8-bit bus as two bytes. A count strobe and a direction input move the counter on each rising clock edge. A 16-bit snapshot register copies the counter on every rising edge, so the host sees a value at most one cycle old. While a two-byte read is in progress, a read-tracking state machine freezes the snapshot. This keeps the high and low bytes from the same instant. Meanwhile the counter keeps counting, and the snapshot catches up as soon as the read ends.

The read-tracking machine samples the active-low output enable and the byte select on the falling clock edge. It has three states:
- `RD_IDLE`: no read is in progress, and the snapshot tracks the counter.
- `RD_HIGH_HELD`: the high byte has been read, and the snapshot is frozen.
- `RD_LOW_DONE`: the low byte has been read, and the snapshot is still frozen.

Its named transitions are:
- *start_read*: `RD_IDLE` to `RD_HIGH_HELD`.
- *low_read*: `RD_HIGH_HELD` to `RD_LOW_DONE`.
- *reread_high*: `RD_LOW_DONE` to `RD_HIGH_HELD`.
- *release*: `RD_LOW_DONE` to `RD_IDLE`.

In every other case the machine holds its state. A host that keeps the byte select high reads only the low byte and never freezes the snapshot. The tri-state bus is modelled as a data value plus an enable.

Top module: `qcr_reader`

## Requirements
- R1: While `rst_n` is low, the counter, the snapshot and the read state are cleared at once, without waiting for a clock. `inhibit` reads 0 and `bus_data` reads 0x00.
- R2: At each rising edge with `cnt_stb`=1, the counter goes up by one if `cnt_up`=1 and down by one if `cnt_up`=0. With `cnt_stb`=0 it holds its value.
- R3: The counter wraps modulo 65536: 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.
- R4: At each rising edge where `inhibit` is 0, the snapshot takes the counter value held just before that edge.
- R5 (start_read): A falling edge in `RD_IDLE` with `oe_n`=0 and `sel`=0 moves to `RD_HIGH_HELD`, and `inhibit` becomes 1.
- R6 (low_read): A falling edge in `RD_HIGH_HELD` with `oe_n`=0 and `sel`=1 moves to `RD_LOW_DONE`, and `inhibit` stays 1.
- R7 (release): A falling edge in `RD_LOW_DONE` with `oe_n`=1 moves to `RD_IDLE`, and `inhibit` becomes 0.
- R8: In `RD_HIGH_HELD`, a falling edge with `oe_n`=1 leaves the state and `inhibit` unchanged.
- R9: While `inhibit` is 1, the snapshot does not change but the counter keeps counting. After release, the snapshot shows the up-to-date count.
- R10: `bus_data` carries snapshot bits 15:8 when `sel`=0 and bits 7:0 when `sel`=1. `bus_en` is the inverse of `oe_n`.
- R11: With `sel` held at 1 from `RD_IDLE`, `inhibit` never rises, and the snapshot keeps tracking the counter (one-byte mode).
- R12 (reread_high): A falling edge in `RD_LOW_DONE` with `oe_n`=0 and `sel`=0 returns to `RD_HIGH_HELD`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count and snapshot change on the rising edge, the read state on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb | input | 1 | Count request for this cycle |
| cnt_up | input | 1 | Count direction: 1 up, 0 down |
| oe_n | input | 1 | Active-low bus output enable |
| sel | input | 1 | Byte select: 0 high byte, 1 low byte |
| bus_data | output | 8 | Selected snapshot byte |
| bus_en | output | 1 | Bus drive enable (high means driven) |
| inhibit | output | 1 | Snapshot freeze flag |

## Verification
The clocked properties check the following on every cycle:
- each counter step, including the wrap;
- the snapshot copying the counter while `inhibit` is 0, and holding still while `inhibit` is 1;
- the falling-edge transitions of the read machine, including the refusal to release from `RD_HIGH_HELD`.

Only the bench scenarios can show these behaviours:
- the snapshot catching up with a counter that moved during a frozen read;
- a complete high-then-low read returning a consistent 16-bit value;
- the asynchronous clear in the middle of a read;
- long one-byte-mode runs.

// File: rtl/qcr_pkg.sv
package qcr_pkg;

    typedef enum logic [1:0] {
        RD_IDLE      = 2'd0,
        RD_HIGH_HELD = 2'd1,
        RD_LOW_DONE  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/qcr_counter.sv
module qcr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         up,
    output logic [W-1:0] cnt_q
);

    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (stb) begin
            if (up) begin
                cnt_d = cnt_q + W'(1);
            end else begin
                cnt_d = cnt_q - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/qcr_snapshot.sv
module qcr_snapshot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic [W-1:0] src,
    output logic [W-1:0] lat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (!freeze) begin
            lat_q <= src;
        end
    end

endmodule

// File: rtl/qcr_read_fsm.sv
module qcr_read_fsm
    import qcr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      oe_n,
    input  logic      sel,
    output rd_state_e state,
    output logic      freeze
);

    rd_state_e state_d;

    // Read tracking advances on the falling edge of the clock.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            RD_IDLE: begin
                // start_read
                if (!oe_n && !sel) begin
                    state_d = RD_HIGH_HELD;
                end
            end
            RD_HIGH_HELD: begin
                // low_read; with oe_n high there is no release from here
                if (!oe_n && sel) begin
                    state_d = RD_LOW_DONE;
                end
            end
            RD_LOW_DONE: begin
                if (oe_n) begin
                    // release
                    state_d = RD_IDLE;
                end else if (!sel) begin
                    // reread_high
                    state_d = RD_HIGH_HELD;
                end
            end
            default: state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            RD_IDLE:      freeze = 1'b0;
            RD_HIGH_HELD: freeze = 1'b1;
            RD_LOW_DONE:  freeze = 1'b1;
            default:      freeze = 1'b0;
        endcase
    end

endmodule

// File: rtl/qcr_byte_mux.sv
module qcr_byte_mux #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2
) (
    input  logic [BYTE_W*NBYTES-1:0] word,
    input  logic                     sel,
    input  logic                     oe_n,
    output logic [BYTE_W-1:0]        data,
    output logic                     en
);

    logic [BYTE_W-1:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    // sel low presents the most significant lane, sel high the least.
    assign data = sel ? lanes[0] : lanes[NBYTES-1];
    assign en   = ~oe_n;

endmodule

// File: rtl/qcr_reader.sv
module qcr_reader
    import qcr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_stb,
    input  logic              cnt_up,
    input  logic              oe_n,
    input  logic              sel,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_en,
    output logic              inhibit
);

    localparam int NBYTES = 2;
    localparam int CNT_W  = BYTE_W * NBYTES;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lat_q;
    rd_state_e        rd_state;

    qcr_counter #(.W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (cnt_stb),
        .up    (cnt_up),
        .cnt_q (cnt_q)
    );

    qcr_read_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_n   (oe_n),
        .sel    (sel),
        .state  (rd_state),
        .freeze (inhibit)
    );

    qcr_snapshot #(.W(CNT_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (inhibit),
        .src    (cnt_q),
        .lat_q  (lat_q)
    );

    qcr_byte_mux #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_mux (
        .word (lat_q),
        .sel  (sel),
        .oe_n (oe_n),
        .data (bus_data),
        .en   (bus_en)
    );

endmodule

// File: rtl/qcr_reader_chk.sv
module qcr_reader_chk
    import qcr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_stb,
    input logic         cnt_up,
    input logic         oe_n,
    input logic         sel,
    input logic         inhibit,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] lat_q,
    input rd_state_e    rd_state
);

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_stb && cnt_up) |=> cnt_q == W'($past(cnt_q) + W'(1))); // R3
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_stb && !cnt_up) |=> cnt_q == W'($past(cnt_q) - W'(1))); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_stb |=> $stable(cnt_q)); // R2
    AST_SNAP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |=> lat_q == $past(cnt_q)); // R4
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> $stable(lat_q)); // R9
    AST_START_READ: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_state == RD_IDLE && !oe_n && !sel) |=> inhibit); // R5
    AST_LOW_READ: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_state == RD_HIGH_HELD && !oe_n && sel) |=> rd_state == RD_LOW_DONE); // R6
    AST_RELEASE: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_state == RD_LOW_DONE && oe_n) |=> !inhibit); // R7
    AST_NO_EARLY_RELEASE: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_state == RD_HIGH_HELD && oe_n) |=> rd_state == RD_HIGH_HELD); // R8
    AST_ONE_BYTE_MODE: assert property (@(negedge clk) disable iff (!rst_n)
        (!inhibit && sel) |=> !inhibit); // R11
    AST_REREAD_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_state == RD_LOW_DONE && !oe_n && !sel) |=> rd_state == RD_HIGH_HELD); // R12

endmodule

bind qcr_reader qcr_reader_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_stb  (cnt_stb),
    .cnt_up   (cnt_up),
    .oe_n     (oe_n),
    .sel      (sel),
    .inhibit  (inhibit),
    .cnt_q    (cnt_q),
    .lat_q    (lat_q),
    .rd_state (rd_state)
);

// File: tb/qcr_reader_test.sv
`timescale 1ns/1ps
module qcr_reader_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_stb = 1'b0;
    logic       cnt_up = 1'b0;
    logic       oe_n = 1'b1;
    logic       sel = 1'b0;
    logic [7:0] bus_data;
    logic       bus_en;
    logic       inhibit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench model of the expected state
    logic [15:0] m_cnt = '0;
    logic [15:0] m_lat = '0;
    int          m_st = 0;   // 0 idle, 1 high held, 2 low done

    always #2 clk = ~clk;

    qcr_reader uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_stb  (cnt_stb),
        .cnt_up   (cnt_up),
        .oe_n     (oe_n),
        .sel      (sel),
        .bus_data (bus_data),
        .bus_en   (bus_en),
        .inhibit  (inhibit)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int next_state(input int st, input logic oen, input logic s);
        int n = st;
        if (st == 0 && !oen && !s) n = 1;
        else if (st == 1 && !oen && s) n = 2;
        else if (st == 2 && oen) n = 0;
        else if (st == 2 && !oen && !s) n = 1;
        return n;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] lat, input logic s);
        return s ? lat[7:0] : lat[15:8];
    endfunction

    // One clock cycle: drive after the rising edge, check after the falling edge.
    task automatic step(input string tag, input logic stb, input logic up,
                        input logic oen, input logic s);
        @(posedge clk);
        #1;
        cnt_stb = stb; cnt_up = up; oe_n = oen; sel = s;
        #2;
        m_st = next_state(m_st, oen, s);
        chk(tag, "inhibit", {15'd0, inhibit}, {15'd0, (m_st != 0)});
        chk(tag, "bus_en", {15'd0, bus_en}, {15'd0, ~oen});
        chk(tag, "bus_data", {8'd0, bus_data}, {8'd0, exp_byte(m_lat, s)});
        // model of the coming rising edge
        if (m_st == 0) m_lat = m_cnt;
        if (stb) m_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        cnt_stb = 1'b0; oe_n = 1'b1; sel = 1'b0;
        rst_n = 1'b0;
        m_cnt = '0; m_lat = '0; m_st = 0;
        #0.5;
        chk("R1", "inhibit in reset", {15'd0, inhibit}, 16'd0);
        chk("R1", "bus_data in reset", {8'd0, bus_data}, 16'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        step("R1", 0, 0, 1, 0);
        step("R1", 0, 0, 1, 1);

        // R2: up and down counting, holding
        repeat (5) step("R2", 1, 1, 1, 1);
        repeat (2) step("R2", 1, 0, 1, 1);
        repeat (2) step("R2", 0, 1, 1, 1);

        // R3: wrap downward through zero and back
        repeat (3) step("R3", 1, 0, 1, 1);
        repeat (3) step("R3", 1, 0, 1, 0);
        repeat (2) step("R3", 0, 0, 1, 0);
        repeat (4) step("R3", 1, 1, 1, 1);
        step("R3", 0, 1, 1, 0);

        // R5, R6, R7, R9: full read while counting
        repeat (300) step("R4", 1, 1, 1, 1);
        step("R5", 1, 1, 0, 0);
        repeat (3) step("R9", 1, 1, 0, 0);
        step("R6", 1, 1, 0, 1);
        step("R9", 1, 1, 0, 1);
        step("R7", 1, 1, 1, 1);
        step("R9", 0, 1, 1, 0);
        step("R9", 0, 1, 1, 1);

        // R8: oe_n high while only the high byte was read
        step("R5", 0, 0, 0, 0);
        repeat (3) step("R8", 1, 0, 1, 0);
        step("R6", 1, 0, 0, 1);
        // R12: re-read the high byte
        step("R12", 1, 0, 0, 0);
        step("R12", 0, 0, 1, 1);
        step("R6", 0, 0, 0, 1);
        step("R7", 0, 0, 1, 0);

        // R11: one-byte mode
        repeat (40) step("R11", 1, 1, 0, 1);
        repeat (10) step("R11", 1, 0, 0, 1);

        // R1: asynchronous clear in the middle of a read
        step("R5", 1, 1, 0, 0);
        do_reset();
        step("R1", 0, 0, 1, 0);

        // R10: random mixed traffic with reads
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] r = 4'($urandom());
            step("R10", r[0], r[1], r[2] & r[3], 1'($urandom()));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule